// File: doc/BRIEF.md
# I2C Clock Phase Generator with Line Deglitching

This block produces the SCL waveform of an I2C master. It pulls SCL low for a programmed number of clock cycles and then releases it. After the release it waits until the line is actually seen high, and only then counts the high phase. A target that stretches the clock therefore lengthens the high time and never shortens it. Two packed count words are held side by side, one for standard speed and one for fast speed, and a single select input chooses between them. Before a count is used it is raised to a floor that depends on the deglitch length, so the filter can never swallow a whole phase.

Both bus lines pass through a programmable glitch filter before any logic uses them. A byte engine attached to the block receives two single-cycle strobes. The first marks the point in the low phase where SDA may change, which is a programmable hold delay with a floor of two cycles. The second marks the first counted high cycle, where SDA should be sampled.

Top module: `scl_timing_gen`

## Requirements
- R1: During and right after reset, sclDriveLow, holdStb and sampleStb are 0 and both filtered lines (sclFilt, sdaFilt) read 1.
- R2: Each low phase drives sclDriveLow for exactly L cycles. L is the selected low field (bits 15:0), except that when that field is at most spikeLen+7, L is spikeLen+8.
- R3: The high count H is the selected high field (bits 31:16), except that when that field is at most spikeLen+5, H is spikeLen+6. With no stretching, each release of sclDriveLow lasts H+spikeLen+3 cycles.
- R4: speedFast=0 takes both fields from stdCounts and speedFast=1 takes both fields from fastCounts. The word that is not selected has no effect on the phases.
- R5: A filtered line changes only after the raw input has held a new level for spikeLen+1 consecutive clock samples, and it then changes spikeLen+2 cycles after the raw change. A pulse of spikeLen cycles or fewer leaves the filtered output unchanged.
- R6: In each low phase, holdStb pulses for exactly one cycle, D cycles after sclDriveLow rises, where D is sdaHold when sdaHold is 2 or more and D is 2 otherwise.
- R7: sampleStb pulses for exactly one cycle per high phase, spikeLen+3 cycles after the release when there is no stretching, and only while sclFilt is 1.
- R8: If SCL is held low externally for S cycles after the release, the high count does not start, and the release lasts S+H+spikeLen+3 cycles.
- R9: When enable is 0, the block completes the phase pair it is in and then leaves sclDriveLow at 0 until enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL phase sequence |
| speedFast | input | 1 | 0 selects stdCounts, 1 selects fastCounts |
| spikeLen | input | 8 | Longest rejected glitch, in cycles |
| stdCounts | input | 32 | Standard speed word: high count in 31:16, low count in 15:0 |
| fastCounts | input | 32 | Fast speed word: high count in 31:16, low count in 15:0 |
| sdaHold | input | 16 | SDA hold delay after the SCL fall, in cycles |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sclFilt | output | 1 | Deglitched SCL level |
| sdaFilt | output | 1 | Deglitched SDA level |
| sclDriveLow | output | 1 | 1 pulls SCL low (open-drain enable) |
| holdStb | output | 1 | SDA may change in this cycle |
| sampleStb | output | 1 | First counted high cycle; sample SDA |

## Verification
A phase state or phase counter that goes wrong shows up at the ports within one SCL period. It appears as a low or high run of the wrong length on sclDriveLow, or as a strobe that is missing, doubled or out of place, so every phase is measured as an edge-to-edge cycle count. A wrong filter counter shows up as a change on sclFilt or sdaFilt that comes one cycle early or late. The bench applies glitches of exactly spikeLen and spikeLen+1 cycles so that an off-by-one in the filter appears immediately. The clamp boundaries are tested on both sides, and one run uses a deliberately bad word in the speed slot that is not selected, so that a wrong select is exposed.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic lowDone;
    logic highDone;
    logic holdHit;
    logic cntZero;
    logic sclHigh;
  } dpStat_t;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int SPK_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SPK_W-1:0] spikeLen,
  input  logic             lineIn,
  output logic             lineOut
);
  logic             rawQ;
  logic [SPK_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ    <= 1'b1;
      lineOut <= 1'b1;
      runCnt  <= '0;
    end else begin
      rawQ <= lineIn;
      if (rawQ == lineOut) begin
        runCnt <= '0;
      end else if (runCnt >= spikeLen) begin
        lineOut <= rawQ;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               speedFast,
  input  logic [SPK_W-1:0]   spikeLen,
  input  logic [2*CNT_W-1:0] stdCounts,
  input  logic [2*CNT_W-1:0] fastCounts,
  input  logic [CNT_W-1:0]   sdaHold,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  dpCtrl_t            ctrl,
  output dpStat_t            stat,
  output logic               sclFilt,
  output logic               sdaFilt
);
  localparam int NLINES = 2;
  localparam logic [CNT_W-1:0] HOLD_MIN = CNT_W'(2);

  logic [NLINES-1:0] rawLines;
  logic [NLINES-1:0] cleanLines;
  assign rawLines = {sdaIn, sclIn};

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_filt
    scl_line_filter #(.SPK_W(SPK_W)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .spikeLen(spikeLen),
      .lineIn  (rawLines[gi]),
      .lineOut (cleanLines[gi])
    );
  end

  assign sclFilt = cleanLines[0];
  assign sdaFilt = cleanLines[1];

  logic [2*CNT_W-1:0] selWord;
  logic [CNT_W-1:0]   hiReq, loReq, spkExt;
  logic [CNT_W-1:0]   effHigh, effLow, effHold;

  always_comb begin
    selWord = speedFast ? fastCounts : stdCounts;
    hiReq   = selWord[2*CNT_W-1:CNT_W];
    loReq   = selWord[CNT_W-1:0];
    spkExt  = CNT_W'(spikeLen);
    effLow  = (loReq <= spkExt + CNT_W'(7)) ? spkExt + CNT_W'(8) : loReq;
    effHigh = (hiReq <= spkExt + CNT_W'(5)) ? spkExt + CNT_W'(6) : hiReq;
    effHold = (sdaHold < HOLD_MIN) ? HOLD_MIN : sdaHold;
  end

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctrl.clrCnt) phaseCnt <= '0;
    else if (ctrl.cntEn)  phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    stat.lowDone  = (phaseCnt == effLow - 1'b1);
    stat.highDone = (phaseCnt == effHigh - 1'b1);
    stat.holdHit  = (phaseCnt == effHold);
    stat.cntZero  = (phaseCnt == '0);
    stat.sclHigh  = sclFilt;
  end
endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
  import scl_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    sclDriveLow,
  output logic    holdStb,
  output logic    sampleStb
);
  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext   = phase;
    ctrl.clrCnt = 1'b0;
    case (phase)
      PH_IDLE: if (enable) begin
        phaseNext   = PH_LOW;
        ctrl.clrCnt = 1'b1;
      end
      PH_LOW: if (stat.lowDone) begin
        phaseNext   = PH_WAIT;
        ctrl.clrCnt = 1'b1;
      end
      PH_WAIT: begin
        ctrl.clrCnt = 1'b1;
        if (stat.sclHigh) phaseNext = PH_HIGH;
      end
      PH_HIGH: if (stat.highDone) begin
        phaseNext   = enable ? PH_LOW : PH_IDLE;
        ctrl.clrCnt = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign ctrl.cntEn  = (phase == PH_LOW) || (phase == PH_HIGH);
  assign sclDriveLow = (phase == PH_LOW);
  assign holdStb     = (phase == PH_LOW) && stat.holdHit;
  assign sampleStb   = (phase == PH_HIGH) && stat.cntZero;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               speedFast,
  input  logic [SPK_W-1:0]   spikeLen,
  input  logic [2*CNT_W-1:0] stdCounts,
  input  logic [2*CNT_W-1:0] fastCounts,
  input  logic [CNT_W-1:0]   sdaHold,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sclFilt,
  output logic               sdaFilt,
  output logic               sclDriveLow,
  output logic               holdStb,
  output logic               sampleStb
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  scl_timing_dp #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .speedFast (speedFast),
    .spikeLen  (spikeLen),
    .stdCounts (stdCounts),
    .fastCounts(fastCounts),
    .sdaHold   (sdaHold),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctrl      (ctrl),
    .stat      (stat),
    .sclFilt   (sclFilt),
    .sdaFilt   (sdaFilt)
  );

  scl_timing_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .stat       (stat),
    .ctrl       (ctrl),
    .sclDriveLow(sclDriveLow),
    .holdStb    (holdStb),
    .sampleStb  (sampleStb)
  );
endmodule

// File: rtl/scl_timing_gen_checker.sv
module scl_timing_gen_checker #(
  parameter int SPK_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [SPK_W-1:0] spikeLen,
  input logic             sdaIn,
  input logic             sclFilt,
  input logic             sdaFilt,
  input logic             sclDriveLow,
  input logic             holdStb,
  input logic             sampleStb
);
  int unsigned lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowRun <= 0;
    else if (sclDriveLow) lowRun <= lowRun + 1;
    else                  lowRun <= 0;
  end

  // R2: a low phase never ends before the clamp floor
  a_r2_low_floor: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> lowRun >= 32'(spikeLen) + 8);

  // R6: the hold strobe falls inside the low phase and is a single cycle
  a_r6_hold_in_low: assert property (@(posedge clk) disable iff (!rstN)
    holdStb |-> sclDriveLow);
  a_r6_hold_single: assert property (@(posedge clk) disable iff (!rstN)
    holdStb |=> !holdStb);

  // R7: sampling only happens with SCL seen high
  a_r7_sample_high: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> sclFilt);

  // R5: a filtered change always takes the level the raw line had
  a_r5_filter_level: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaFilt) |-> sdaFilt == $past(sdaIn, 2));

  // R9: disabled and released stays released
  a_r9_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !sclDriveLow) |=> !sclDriveLow);
endmodule

bind scl_timing_gen scl_timing_gen_checker #(.SPK_W(SPK_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .spikeLen   (spikeLen),
  .sdaIn      (sdaIn),
  .sclFilt    (sclFilt),
  .sdaFilt    (sdaFilt),
  .sclDriveLow(sclDriveLow),
  .holdStb    (holdStb),
  .sampleStb  (sampleStb)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        speedFast = 1'b0;
  logic [7:0]  spikeLen = 8'd2;
  logic [31:0] stdCounts = '0;
  logic [31:0] fastCounts = '0;
  logic [15:0] sdaHold = 16'd2;
  logic        stretch = 1'b0;
  logic        sdaIn = 1'b1;
  logic        sclIn;
  logic        sclFilt, sdaFilt, sclDriveLow, holdStb, sampleStb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sclIn = !(sclDriveLow || stretch);

  scl_timing_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .speedFast(speedFast),
    .spikeLen(spikeLen), .stdCounts(stdCounts), .fastCounts(fastCounts),
    .sdaHold(sdaHold), .sclIn(sclIn), .sdaIn(sdaIn), .sclFilt(sclFilt),
    .sdaFilt(sdaFilt), .sclDriveLow(sclDriveLow), .holdStb(holdStb),
    .sampleStb(sampleStb)
  );

  typedef struct packed {
    logic        fast;
    logic [7:0]  spk;
    logic [31:0] stdW;
    logic [31:0] fastW;
    logic [15:0] hold;
    logic [15:0] expLow;
    logic [15:0] expHigh;
    logic [15:0] expHold;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd2,  {16'd20, 16'd30}, {16'd99, 16'd99}, 16'd5, 16'd30, 16'd20, 16'd5},
    '{1'b1, 8'd2,  {16'd40, 16'd50}, {16'd12, 16'd15}, 16'd3, 16'd15, 16'd12, 16'd3},
    '{1'b0, 8'd4,  {16'd9,  16'd11}, {16'd70, 16'd70}, 16'd0, 16'd12, 16'd10, 16'd2},
    '{1'b1, 8'd4,  {16'd80, 16'd80}, {16'd10, 16'd12}, 16'd1, 16'd12, 16'd10, 16'd2},
    '{1'b0, 8'd0,  {16'd6,  16'd8},  {16'd1,  16'd1},  16'd7, 16'd8,  16'd6,  16'd7},
    '{1'b1, 8'd10, {16'd5,  16'd5},  {16'd3,  16'd3},  16'd9, 16'd18, 16'd16, 16'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one SCL period measured edge to edge; optional external stretch
  task automatic runVec(input vec_t v, input int stretchLen, input string tag);
    int idx, holdAt, holdCnt, sampAt, sampCnt, lowLen, relLen;
    speedFast = v.fast; spikeLen = v.spk; stdCounts = v.stdW;
    fastCounts = v.fastW; sdaHold = v.hold;
    repeat (30) @(negedge clk);
    enable = 1'b1;
    idx = 0;
    while (!sclDriveLow && idx < 100) begin @(negedge clk); idx++; end
    idx = 0; holdAt = -1; holdCnt = 0;
    while (sclDriveLow && idx < 5000) begin
      if (holdStb) begin holdAt = idx; holdCnt++; end
      idx++; @(negedge clk);
    end
    lowLen = idx;
    idx = 0; sampAt = -1; sampCnt = 0;
    while (!sclDriveLow && idx < 5000) begin
      if (stretchLen > 0 && idx == 0) stretch = 1'b1;
      if (idx == stretchLen) stretch = 1'b0;
      if (sampleStb) begin sampAt = idx; sampCnt++; end
      idx++; @(negedge clk);
    end
    relLen = idx;
    enable = 1'b0;
    chk({"R2/R4 low length ", tag}, lowLen, int'(v.expLow));
    chk({"R6 hold offset ", tag}, holdAt, int'(v.expHold));
    chk({"R6 hold count ", tag}, holdCnt, 1);
    if (stretchLen > 0)
      chk({"R8 stretched release ", tag}, relLen, stretchLen + int'(v.expHigh) + int'(v.spk) + 3);
    else begin
      chk({"R3/R4 release length ", tag}, relLen, int'(v.expHigh) + int'(v.spk) + 3);
      chk({"R7 sample offset ", tag}, sampAt, int'(v.spk) + 3);
    end
    chk({"R7 sample count ", tag}, sampCnt, 1);
    // R9: finish the pair, then stay released
    repeat (200) @(negedge clk);
    idx = 0;
    for (int k = 0; k < 60; k++) begin
      if (sclDriveLow) idx++;
      @(negedge clk);
    end
    chk({"R9 idle after disable ", tag}, idx, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int bad;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", int'(sclDriveLow), 0);
    chk("R1 filt in reset", int'({sclFilt, sdaFilt}), 3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({holdStb, sampleStb, sclDriveLow}), 0);
    chk("R1 filt after reset", int'({sclFilt, sdaFilt}), 3);

    for (int i = 0; i < NVEC; i++)
      runVec(VECS[i], 0, $sformatf("vec%0d", i));

    // R8 clock stretch on vector 0 settings
    runVec(VECS[0], 20, "stretch");

    // R5 filter boundary, spikeLen = 3, block idle
    spikeLen = 8'd3;
    repeat (10) @(negedge clk);
    sdaIn = 1'b0; stretch = 1'b1;
    repeat (3) @(negedge clk);
    sdaIn = 1'b1; stretch = 1'b0;
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      if (!sdaFilt || !sclFilt) bad++;
      @(negedge clk);
    end
    chk("R5 glitch of spikeLen rejected", bad, 0);

    sdaIn = 1'b0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R5 no change before spikeLen+2", int'(sdaFilt), 1);
    sdaIn = 1'b1;
    @(negedge clk);
    chk("R5 accepted at spikeLen+2", int'(sdaFilt), 0);
    repeat (20) @(negedge clk);
    chk("R5 returns high", int'(sdaFilt), 1);

    report();
  end
endmodule